// File: doc/BRIEF.md
# Segmented Address Extension Unit

This block widens a 16-bit virtual address into a 22-bit physical address. It holds three 6-bit segment registers, one each for code, interrupts and DMA. The access type presented with each address picks which register supplies the upper six bits. The virtual address passes through unchanged as the low sixteen bits, so memory is seen as 64 segments of 64 KB each.

Instruction fetches and code-space data accesses use the code segment. Interrupt vector and service accesses use the interrupt segment. A DMA access uses the DMA segment when its page-select flag is set, and the interrupt segment when the flag is clear.

Software reads and writes the registers through a register-file port, at register addresses 244 (code), 248 (interrupt) and 249 (DMA). Control flow can also load the code segment. A far jump or far call supplies a new segment, and a far return supplies the segment popped from the stack.

Top module: `seg_addr_ext`

## Requirements
- R1: After reset the code segment is 0. A read at address 244 then returns 00h, and a fetch produces an upper address of 0. The interrupt and DMA segments have no defined reset value.
- R2: `paddr_o[15:0]` always equals `vaddr_i`, combinationally.
- R3: Access type 0 (fetch) and access type 1 (code-space data) take `paddr_o[21:16]` from the code segment.
- R4: Access type 2 (interrupt vector or service) takes `paddr_o[21:16]` from the interrupt segment.
- R5: Access type 3 (DMA) takes `paddr_o[21:16]` from the DMA segment when `dma_page_sel_i` is 1, and from the interrupt segment when it is 0.
- R6: A write with `reg_we_i` high at address 244, 248 or 249 stores `reg_wdata_i[5:0]` into the code, interrupt or DMA segment. Data bits 7:6 are ignored, and readback always returns 0 in bits 7:6.
- R7: A write becomes visible on `paddr_o` and `reg_rdata_o` from the cycle after the clock edge that takes it, and not before.
- R8: A read at any other address returns 00h. A write to any other address changes no segment.
- R9: `far_ld_i` loads the code segment from `far_seg_i` on the next clock edge.
- R10: `ret_ld_i` loads the code segment from `ret_seg_i` on the next clock edge.
- R11: Loads of the code segment follow a fixed priority. `far_ld_i` wins over `ret_ld_i`, and both win over a simultaneous bus write to address 244.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address for read and write |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register readback, combinational |
| far_ld_i | input | 1 | Far jump or far call: load the code segment |
| far_seg_i | input | 6 | Target segment of the far jump or far call |
| ret_ld_i | input | 1 | Far return: restore the code segment |
| ret_seg_i | input | 6 | Segment popped from the stack |
| acc_type_i | input | 2 | 0 fetch, 1 code data, 2 interrupt, 3 DMA |
| dma_page_sel_i | input | 1 | DMA segment source: 1 DMA segment, 0 interrupt segment |
| vaddr_i | input | 16 | Virtual address |
| paddr_o | output | 22 | Physical address |

## Verification
The three segments are loaded with distinct values (such as 3Fh, 15h and 2Ah), and the bench then steps through all four access types and both page-select values. Each upper-address result can therefore have come from only one register, and a wrong selection shows up as a wrong value. Virtual addresses of all zeros, all ones and alternating bits show that the low half passes through without mixing with the segment bits. Simultaneous control and bus loads separate the three load priorities. A check just before the writing edge separates the registered update from a combinational path.

// File: rtl/seg_addr_ext_pkg.sv
package seg_addr_ext_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_CDATA = 2'd1,
    ACC_IRQ   = 2'd2,
    ACC_DMA   = 2'd3
  } acc_e;

  localparam int unsigned NSEG    = 3;
  localparam int unsigned SEG_CODE = 0;
  localparam int unsigned SEG_IRQ  = 1;
  localparam int unsigned SEG_DMA  = 2;
endpackage

// File: rtl/seg_reg.sv
module seg_reg #(
  parameter int unsigned      SEG_W   = 6,
  parameter bit               HAS_RST = 1'b0,
  parameter logic [SEG_W-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_ld_i,
  input  logic [SEG_W-1:0] ctl_val_i,
  input  logic             bus_we_i,
  input  logic [SEG_W-1:0] bus_val_i,
  output logic [SEG_W-1:0] q_o
);
  if (HAS_RST) begin : g_rst
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o <= RST_VAL;
      else if (ctl_ld_i) q_o <= ctl_val_i;
      else if (bus_we_i) q_o <= bus_val_i;
    end
  end else begin : g_nrst
    // no reset value defined for this segment
    logic unused_rst;
    assign unused_rst = rst_ni;
    always_ff @(posedge clk_i) begin
      if (ctl_ld_i)      q_o <= ctl_val_i;
      else if (bus_we_i) q_o <= bus_val_i;
    end
  end
endmodule

// File: rtl/seg_regport.sv
module seg_regport #(
  parameter int unsigned SEG_W      = 6,
  parameter int unsigned REG_AW     = 8,
  parameter int unsigned REG_DW     = 8,
  parameter int unsigned NSEG       = 3,
  parameter int unsigned CODE_RADDR = 244,
  parameter int unsigned IRQ_RADDR  = 248,
  parameter int unsigned DMA_RADDR  = 249
) (
  input  logic                       reg_we_i,
  input  logic [REG_AW-1:0]          reg_addr_i,
  input  logic [REG_DW-1:0]          reg_wdata_i,
  input  logic [NSEG-1:0][SEG_W-1:0] seg_q_i,
  output logic [NSEG-1:0]            bus_we_o,
  output logic [SEG_W-1:0]           bus_val_o,
  output logic [REG_DW-1:0]          reg_rdata_o
);
  localparam logic [NSEG-1:0][REG_AW-1:0] RADDR =
    {REG_AW'(DMA_RADDR), REG_AW'(IRQ_RADDR), REG_AW'(CODE_RADDR)};

  logic [NSEG-1:0] hit;

  for (genvar i = 0; i < NSEG; i++) begin : g_dec
    assign hit[i]      = (reg_addr_i == RADDR[i]);
    assign bus_we_o[i] = reg_we_i & hit[i];
  end

  assign bus_val_o = reg_wdata_i[SEG_W-1:0];

  // reserved upper data bits are dropped
  logic [REG_DW-SEG_W-1:0] unused_wdata;
  assign unused_wdata = reg_wdata_i[REG_DW-1:SEG_W];

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (hit[i]) reg_rdata_o[SEG_W-1:0] = seg_q_i[i];
    end
  end
endmodule

// File: rtl/seg_addr_mux.sv
module seg_addr_mux
  import seg_addr_ext_pkg::*;
#(
  parameter int unsigned SEG_W = 6,
  parameter int unsigned VA_W  = 16,
  localparam int unsigned PA_W = SEG_W + VA_W
) (
  input  acc_e             acc_type_i,
  input  logic             dma_page_sel_i,
  input  logic [SEG_W-1:0] code_seg_i,
  input  logic [SEG_W-1:0] irq_seg_i,
  input  logic [SEG_W-1:0] dma_seg_i,
  input  logic [VA_W-1:0]  vaddr_i,
  output logic [PA_W-1:0]  paddr_o
);
  logic [SEG_W-1:0] seg_sel;

  always_comb begin
    unique case (acc_type_i)
      ACC_FETCH, ACC_CDATA: seg_sel = code_seg_i;
      ACC_IRQ:              seg_sel = irq_seg_i;
      ACC_DMA:              seg_sel = dma_page_sel_i ? dma_seg_i : irq_seg_i;
      default:              seg_sel = code_seg_i;
    endcase
  end

  assign paddr_o = {seg_sel, vaddr_i};
endmodule

// File: rtl/seg_addr_ext.sv
module seg_addr_ext
  import seg_addr_ext_pkg::*;
#(
  parameter int unsigned SEG_W      = 6,
  parameter int unsigned VA_W       = 16,
  parameter int unsigned REG_AW     = 8,
  parameter int unsigned REG_DW     = 8,
  parameter int unsigned CODE_RADDR = 244,
  parameter int unsigned IRQ_RADDR  = 248,
  parameter int unsigned DMA_RADDR  = 249,
  localparam int unsigned PA_W      = SEG_W + VA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  input  logic              far_ld_i,
  input  logic [SEG_W-1:0]  far_seg_i,
  input  logic              ret_ld_i,
  input  logic [SEG_W-1:0]  ret_seg_i,
  input  logic [1:0]        acc_type_i,
  input  logic              dma_page_sel_i,
  input  logic [VA_W-1:0]   vaddr_i,
  output logic [PA_W-1:0]   paddr_o
);
  logic [NSEG-1:0][SEG_W-1:0] seg_q;
  logic [NSEG-1:0]            bus_we;
  logic [SEG_W-1:0]           bus_val;
  logic                       code_ld;
  logic [SEG_W-1:0]           code_val;

  // far jump/call outranks far return
  assign code_ld  = far_ld_i | ret_ld_i;
  assign code_val = far_ld_i ? far_seg_i : ret_seg_i;

  seg_regport #(
    .SEG_W(SEG_W), .REG_AW(REG_AW), .REG_DW(REG_DW), .NSEG(NSEG),
    .CODE_RADDR(CODE_RADDR), .IRQ_RADDR(IRQ_RADDR), .DMA_RADDR(DMA_RADDR)
  ) u_regport (
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .seg_q_i    (seg_q),
    .bus_we_o   (bus_we),
    .bus_val_o  (bus_val),
    .reg_rdata_o(reg_rdata_o)
  );

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    localparam bit IS_CODE = (i == SEG_CODE);
    seg_reg #(
      .SEG_W  (SEG_W),
      .HAS_RST(IS_CODE),
      .RST_VAL('0)
    ) u_seg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ctl_ld_i (IS_CODE ? code_ld : 1'b0),
      .ctl_val_i(code_val),
      .bus_we_i (bus_we[i]),
      .bus_val_i(bus_val),
      .q_o      (seg_q[i])
    );
  end

  seg_addr_mux #(.SEG_W(SEG_W), .VA_W(VA_W)) u_mux (
    .acc_type_i    (acc_e'(acc_type_i)),
    .dma_page_sel_i(dma_page_sel_i),
    .code_seg_i    (seg_q[SEG_CODE]),
    .irq_seg_i     (seg_q[SEG_IRQ]),
    .dma_seg_i     (seg_q[SEG_DMA]),
    .vaddr_i       (vaddr_i),
    .paddr_o       (paddr_o)
  );
endmodule

// File: rtl/seg_addr_ext_chk.sv
module seg_addr_ext_chk #(
  parameter int unsigned SEG_W     = 6,
  parameter int unsigned VA_W      = 16,
  parameter int unsigned REG_AW    = 8,
  parameter int unsigned REG_DW    = 8,
  parameter int unsigned IRQ_RADDR = 248,
  localparam int unsigned PA_W     = SEG_W + VA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [REG_DW-1:0] reg_wdata_i,
  input logic [REG_DW-1:0] reg_rdata_o,
  input logic              far_ld_i,
  input logic [SEG_W-1:0]  far_seg_i,
  input logic              ret_ld_i,
  input logic [SEG_W-1:0]  ret_seg_i,
  input logic [1:0]        acc_type_i,
  input logic              dma_page_sel_i,
  input logic [VA_W-1:0]   vaddr_i,
  input logic [PA_W-1:0]   paddr_o,
  input logic [2:0][SEG_W-1:0] seg_q
);
  // R2
  vaddr_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paddr_o[VA_W-1:0] == vaddr_i);

  // R3
  code_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_type_i == 2'd0 || acc_type_i == 2'd1) |-> paddr_o[PA_W-1:VA_W] == seg_q[0]);

  // R4
  irq_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_type_i == 2'd2) |-> paddr_o[PA_W-1:VA_W] === seg_q[1]);

  // R5
  dma_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_type_i == 2'd3) |->
      paddr_o[PA_W-1:VA_W] === (dma_page_sel_i ? seg_q[2] : seg_q[1]));

  // R6
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[REG_DW-1:SEG_W] == '0);

  // R6
  irq_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == REG_AW'(IRQ_RADDR)) |=> seg_q[1] == $past(reg_wdata_i[SEG_W-1:0]));

  // R9 R11
  far_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    far_ld_i |=> seg_q[0] == $past(far_seg_i));

  // R10 R11
  ret_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_ld_i && !far_ld_i) |=> seg_q[0] == $past(ret_seg_i));
endmodule

bind seg_addr_ext seg_addr_ext_chk #(
  .SEG_W(SEG_W), .VA_W(VA_W), .REG_AW(REG_AW), .REG_DW(REG_DW), .IRQ_RADDR(IRQ_RADDR)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_we_i      (reg_we_i),
  .reg_addr_i    (reg_addr_i),
  .reg_wdata_i   (reg_wdata_i),
  .reg_rdata_o   (reg_rdata_o),
  .far_ld_i      (far_ld_i),
  .far_seg_i     (far_seg_i),
  .ret_ld_i      (ret_ld_i),
  .ret_seg_i     (ret_seg_i),
  .acc_type_i    (acc_type_i),
  .dma_page_sel_i(dma_page_sel_i),
  .vaddr_i       (vaddr_i),
  .paddr_o       (paddr_o),
  .seg_q         (seg_q)
);

// File: tb/seg_addr_ext_bench.sv
module seg_addr_ext_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        far_ld_i = 1'b0;
  logic [5:0]  far_seg_i = '0;
  logic        ret_ld_i = 1'b0;
  logic [5:0]  ret_seg_i = '0;
  logic [1:0]  acc_type_i = '0;
  logic        dma_page_sel_i = 1'b0;
  logic [15:0] vaddr_i = '0;
  logic [21:0] paddr_o;

  int n_chk = 0;
  int n_fail = 0;

  seg_addr_ext u_seg_addr_ext (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    tick();
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    reg_addr_i = a;
    #1;
    chk(req, 32'(reg_rdata_o), 32'(exp));
  endtask

  task automatic addr(input string req, input logic [1:0] t, input logic sel,
                      input logic [15:0] va, input logic [5:0] seg);
    acc_type_i = t; dma_page_sel_i = sel; vaddr_i = va;
    #1;
    chk(req, 32'(paddr_o), 32'({seg, va}));
  endtask

  task automatic t_reset();
    rd("R1 code after reset", 8'd244, 8'h00);
    addr("R1 fetch after reset", 2'd0, 1'b0, 16'h1234, 6'h00);
  endtask

  task automatic t_regs();
    wr(8'd244, 8'hFF);
    wr(8'd248, 8'hD5);
    wr(8'd249, 8'h6A);
    rd("R6 code readback rsvd zero", 8'd244, 8'h3F);
    rd("R6 irq readback", 8'd248, 8'h15);
    rd("R6 dma readback", 8'd249, 8'h2A);
  endtask

  task automatic t_select();
    addr("R3 fetch code", 2'd0, 1'b0, 16'h0000, 6'h3F);
    addr("R3 code data", 2'd1, 1'b1, 16'hFFFF, 6'h3F);
    addr("R4 irq", 2'd2, 1'b1, 16'hA5A5, 6'h15);
    addr("R5 dma sel1", 2'd3, 1'b1, 16'h5A5A, 6'h2A);
    addr("R5 dma sel0", 2'd3, 1'b0, 16'h8001, 6'h15);
    addr("R2 pass ones", 2'd2, 1'b0, 16'hFFFF, 6'h15);
  endtask

  task automatic t_unmapped();
    wr(8'd245, 8'h01);
    wr(8'd0, 8'h02);
    rd("R8 unmapped read", 8'd245, 8'h00);
    rd("R8 code untouched", 8'd244, 8'h3F);
    rd("R8 irq untouched", 8'd248, 8'h15);
    rd("R8 dma untouched", 8'd249, 8'h2A);
  endtask

  task automatic t_timing();
    acc_type_i = 2'd0; vaddr_i = 16'h0100;
    reg_we_i = 1'b1; reg_addr_i = 8'd244; reg_wdata_i = 8'h07;
    #1;
    chk("R7 before edge", 32'(paddr_o), 32'({6'h3F, 16'h0100}));
    tick();
    reg_we_i = 1'b0;
    chk("R7 after edge", 32'(paddr_o), 32'({6'h07, 16'h0100}));
  endtask

  task automatic t_ctl();
    far_ld_i = 1'b1; far_seg_i = 6'h21;
    tick();
    far_ld_i = 1'b0;
    rd("R9 far load", 8'd244, 8'h21);
    ret_ld_i = 1'b1; ret_seg_i = 6'h0C;
    tick();
    ret_ld_i = 1'b0;
    rd("R10 ret load", 8'd244, 8'h0C);
    far_ld_i = 1'b1; far_seg_i = 6'h11; ret_ld_i = 1'b1; ret_seg_i = 6'h22;
    reg_we_i = 1'b1; reg_addr_i = 8'd244; reg_wdata_i = 8'h33;
    tick();
    far_ld_i = 1'b0; ret_ld_i = 1'b0; reg_we_i = 1'b0;
    rd("R11 far wins", 8'd244, 8'h11);
    ret_ld_i = 1'b1; ret_seg_i = 6'h2E;
    reg_we_i = 1'b1; reg_addr_i = 8'd244; reg_wdata_i = 8'h01;
    tick();
    ret_ld_i = 1'b0; reg_we_i = 1'b0;
    rd("R11 ret over write", 8'd244, 8'h2E);
    addr("R9 fetch uses new code", 2'd0, 1'b0, 16'hBEEF, 6'h2E);
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_regs();
    t_select();
    t_unmapped();
    t_timing();
    t_ctl();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #20000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule